// File: doc/BRIEF.md
# Multicycle Processor Main Control Sequencer

This block is the main controller of a multicycle 32-bit load/store processor datapath. It reads the 6-bit opcode field held in the instruction register and walks through a numbered set of states, one per clock cycle. Its outputs are Moore outputs: they depend only on the present state. In each state it drives the datapath controls. These are the memory read and write strobes, the instruction-register load, the unconditional and conditional PC loads, the memory address source, the two ALU operand selects, the ALU operation class, the PC source, the destination register select, the write-back data select and the register-file write enable.

Every instruction starts with a fetch (state 0) and a decode/register-read step (state 1). At the end of decode, holding register A carries the register named by rs and holding register B the register named by rt. From decode the sequencer branches on the opcode into a load, store, register-register, branch-equal, jump or add-immediate path. Each path ends by going back to fetch. The add-immediate path has two dedicated states. The first adds A to the sign-extended immediate, and the second writes the sum into rt. The state number is brought out so that the datapath, or a bench, can see where the sequence stands.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: With `rst` high at a rising clock edge, the next state is 0 (fetch), whatever the current state. The controls of state 0 follow on the next cycle.
- R2: State 0 drives `mem_rd`, `ir_wr` and `pc_wr` to 1, `srcb_sel`=01 (constant 4) and all other controls to 0. This gives `addr_sel`=0 (PC), `srca_sel`=0 (PC), `alu_op`=00 (add) and `pc_src`=00 (ALU result). State 0 always moves to state 1.
- R3: State 1 drives `srca_sel`=0, `srcb_sel`=11 (immediate shifted left by 2) and `alu_op`=00, with all other controls 0.
- R4: Load (opcode 100011) runs states 0,1,2,3,4,0. State 2 drives `srca_sel`=1 (A), `srcb_sel`=10 (sign-extended immediate) and `alu_op`=00. State 3 drives `mem_rd`=1 and `addr_sel`=1. State 4 drives `reg_wr`=1, `wb_sel`=1 (memory data) and `reg_dst`=0 (rt).
- R5: Store (opcode 101011) runs states 0,1,2,5,0. State 2 has the controls of R4, and state 5 drives `mem_wr`=1 and `addr_sel`=1.
- R6: Register-register (opcode 000000) runs states 0,1,6,7,0. State 6 drives `srca_sel`=1, `srcb_sel`=00 (B) and `alu_op`=10 (function field). State 7 drives `reg_dst`=1 (rd), `wb_sel`=0 and `reg_wr`=1.
- R7: Branch-equal (opcode 000100) runs states 0,1,8,0. State 8 drives `srca_sel`=1, `srcb_sel`=00, `alu_op`=01 (subtract), `pc_wr_cond`=1 and `pc_src`=01, with `pc_wr`=0.
- R8: Jump (opcode 000010) runs states 0,1,9,0. State 9 drives `pc_wr`=1 and `pc_src`=10, with all other controls 0.
- R9: Add-immediate (opcode 001000) runs states 0,1,10,11,0. State 10 drives `srca_sel`=1, `srcb_sel`=10 and `alu_op`=00. State 11 drives `reg_wr`=1, `reg_dst`=0 and `wb_sel`=0.
- R10: Any other opcode goes from state 1 straight back to state 0 and asserts no write strobe on the way.
- R11: `reg_wr` is 1 only in states 4, 7 and 11, and `mem_wr` is 1 only in state 5.
- R12: `mem_rd` and `mem_wr` are never 1 together, and `pc_wr` and `pc_wr_cond` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 6 | Opcode field from the instruction register |
| state_o | output | 4 | Present state number |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC load |
| pc_wr_cond | output | 1 | PC load qualified by ALU zero |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU output register |
| srca_sel | output | 1 | ALU port A: 0 PC, 1 register A |
| srcb_sel | output | 2 | ALU port B: 00 B, 01 four, 10 immediate, 11 immediate shifted by 2 |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| reg_dst | output | 1 | Write register: 0 rt, 1 rd |
| wb_sel | output | 1 | Write data: 0 ALU output register, 1 memory data register |
| reg_wr | output | 1 | Register file write enable |

## Verification
The bench follows each opcode through its full state path and compares all controls in every state. A controller that mixed up the store and load split after the address state would write memory on a load. A controller that let add-immediate reuse the register-register write-back would send its result to rd instead of rt. An opcode that is not recognised must fall back to fetch with no write strobe; a decoder that defaulted to any real path would corrupt memory or registers. The bench also asserts reset in the middle of a load. It expects fetch on the next edge, then a normal decode, which catches a reset that waits for the sequence to finish.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

   localparam int OPC_W   = 6;
   localparam int STATE_W = 4;
   localparam int SEL_W   = 2;

   typedef enum logic [STATE_W-1:0] {
      ST_FETCH     = 4'd0,
      ST_DECODE    = 4'd1,
      ST_MEM_ADDR  = 4'd2,
      ST_MEM_READ  = 4'd3,
      ST_LOAD_WB   = 4'd4,
      ST_MEM_WRITE = 4'd5,
      ST_EXEC      = 4'd6,
      ST_ALU_WB    = 4'd7,
      ST_BRANCH    = 4'd8,
      ST_JUMP      = 4'd9,
      ST_ADDI_EXEC = 4'd10,
      ST_ADDI_WB   = 4'd11
   } state_t;

   localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
   localparam logic [OPC_W-1:0] OPC_J     = 6'b000010;
   localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
   localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
   localparam logic [OPC_W-1:0] OPC_LW    = 6'b100011;
   localparam logic [OPC_W-1:0] OPC_SW    = 6'b101011;

   localparam logic [SEL_W-1:0] SRCB_REG   = 2'b00;
   localparam logic [SEL_W-1:0] SRCB_FOUR  = 2'b01;
   localparam logic [SEL_W-1:0] SRCB_IMM   = 2'b10;
   localparam logic [SEL_W-1:0] SRCB_IMMSH = 2'b11;

   localparam logic [SEL_W-1:0] ALU_ADD  = 2'b00;
   localparam logic [SEL_W-1:0] ALU_SUB  = 2'b01;
   localparam logic [SEL_W-1:0] ALU_FUNC = 2'b10;

   localparam logic [SEL_W-1:0] PCS_ALU  = 2'b00;
   localparam logic [SEL_W-1:0] PCS_OUT  = 2'b01;
   localparam logic [SEL_W-1:0] PCS_JUMP = 2'b10;

   typedef struct packed {
      logic             mem_rd;
      logic             mem_wr;
      logic             ir_wr;
      logic             pc_wr;
      logic             pc_wr_cond;
      logic             addr_sel;
      logic             srca_sel;
      logic [SEL_W-1:0] srcb_sel;
      logic [SEL_W-1:0] alu_op;
      logic [SEL_W-1:0] pc_src;
      logic             reg_dst;
      logic             wb_sel;
      logic             reg_wr;
   } ctrl_t;

endpackage

// File: rtl/mc_ctrl_state_reg.sv
module mc_ctrl_state_reg
   import mc_ctrl_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  state_t nxt,
   output state_t cur
);

   always_ff @(posedge clk) begin
      if (rst) cur <= ST_FETCH;
      else     cur <= nxt;
   end

endmodule

// File: rtl/mc_ctrl_next_state.sv
module mc_ctrl_next_state
   import mc_ctrl_pkg::*;
#(
   parameter bit ENABLE_ADDI = 1'b1
) (
   input  state_t           cur,
   input  logic [OPC_W-1:0] op,
   output state_t           nxt
);

   state_t addi_dst;

   generate
      if (ENABLE_ADDI) begin : g_addi
         assign addi_dst = ST_ADDI_EXEC;
      end else begin : g_no_addi
         assign addi_dst = ST_FETCH;
      end
   endgenerate

   always_comb begin
      nxt = ST_FETCH;
      case (cur)
         ST_FETCH:    nxt = ST_DECODE;
         ST_DECODE: begin
            case (op)
               OPC_LW, OPC_SW: nxt = ST_MEM_ADDR;
               OPC_RTYPE:      nxt = ST_EXEC;
               OPC_BEQ:        nxt = ST_BRANCH;
               OPC_J:          nxt = ST_JUMP;
               OPC_ADDI:       nxt = addi_dst;
               default:        nxt = ST_FETCH;
            endcase
         end
         ST_MEM_ADDR: begin
            if (op == OPC_LW)      nxt = ST_MEM_READ;
            else if (op == OPC_SW) nxt = ST_MEM_WRITE;
            else                   nxt = ST_FETCH;
         end
         ST_MEM_READ:  nxt = ST_LOAD_WB;
         ST_EXEC:      nxt = ST_ALU_WB;
         ST_ADDI_EXEC: nxt = ST_ADDI_WB;
         default:      nxt = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mc_ctrl_out_decode.sv
module mc_ctrl_out_decode
   import mc_ctrl_pkg::*;
(
   input  state_t cur,
   output ctrl_t  ctl
);

   always_comb begin
      ctl = '0;
      case (cur)
         ST_FETCH: begin
            ctl.mem_rd   = 1'b1;
            ctl.ir_wr    = 1'b1;
            ctl.pc_wr    = 1'b1;
            ctl.srcb_sel = SRCB_FOUR;
            ctl.alu_op   = ALU_ADD;
            ctl.pc_src   = PCS_ALU;
         end
         ST_DECODE: begin
            ctl.srcb_sel = SRCB_IMMSH;
            ctl.alu_op   = ALU_ADD;
         end
         ST_MEM_ADDR, ST_ADDI_EXEC: begin
            ctl.srca_sel = 1'b1;
            ctl.srcb_sel = SRCB_IMM;
            ctl.alu_op   = ALU_ADD;
         end
         ST_MEM_READ: begin
            ctl.mem_rd   = 1'b1;
            ctl.addr_sel = 1'b1;
         end
         ST_LOAD_WB: begin
            ctl.reg_wr   = 1'b1;
            ctl.wb_sel   = 1'b1;
         end
         ST_MEM_WRITE: begin
            ctl.mem_wr   = 1'b1;
            ctl.addr_sel = 1'b1;
         end
         ST_EXEC: begin
            ctl.srca_sel = 1'b1;
            ctl.srcb_sel = SRCB_REG;
            ctl.alu_op   = ALU_FUNC;
         end
         ST_ALU_WB: begin
            ctl.reg_dst  = 1'b1;
            ctl.reg_wr   = 1'b1;
         end
         ST_BRANCH: begin
            ctl.srca_sel   = 1'b1;
            ctl.srcb_sel   = SRCB_REG;
            ctl.alu_op     = ALU_SUB;
            ctl.pc_wr_cond = 1'b1;
            ctl.pc_src     = PCS_OUT;
         end
         ST_JUMP: begin
            ctl.pc_wr    = 1'b1;
            ctl.pc_src   = PCS_JUMP;
         end
         ST_ADDI_WB: begin
            ctl.reg_wr   = 1'b1;
         end
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
   import mc_ctrl_pkg::*;
#(
   parameter int OP_W        = 6,
   parameter bit ENABLE_ADDI = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] op_i,
   output logic [3:0]      state_o,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic            ir_wr,
   output logic            pc_wr,
   output logic            pc_wr_cond,
   output logic            addr_sel,
   output logic            srca_sel,
   output logic [1:0]      srcb_sel,
   output logic [1:0]      alu_op,
   output logic [1:0]      pc_src,
   output logic            reg_dst,
   output logic            wb_sel,
   output logic            reg_wr
);

   generate
      if (OP_W != OPC_W) begin : g_bad_op_w
         $error("mc_ctrl_fsm: OP_W must equal the opcode field width");
      end
      if (STATE_W != 4) begin : g_bad_state_w
         $error("mc_ctrl_fsm: state port is four bits wide");
      end
   endgenerate

   state_t cur_st;
   state_t nxt_st;
   ctrl_t  ctl;

   mc_ctrl_state_reg u_state (
      .clk (clk),
      .rst (rst),
      .nxt (nxt_st),
      .cur (cur_st)
   );

   mc_ctrl_next_state #(
      .ENABLE_ADDI (ENABLE_ADDI)
   ) u_next (
      .cur (cur_st),
      .op  (op_i),
      .nxt (nxt_st)
   );

   mc_ctrl_out_decode u_out (
      .cur (cur_st),
      .ctl (ctl)
   );

   assign state_o    = cur_st;
   assign mem_rd     = ctl.mem_rd;
   assign mem_wr     = ctl.mem_wr;
   assign ir_wr      = ctl.ir_wr;
   assign pc_wr      = ctl.pc_wr;
   assign pc_wr_cond = ctl.pc_wr_cond;
   assign addr_sel   = ctl.addr_sel;
   assign srca_sel   = ctl.srca_sel;
   assign srcb_sel   = ctl.srcb_sel;
   assign alu_op     = ctl.alu_op;
   assign pc_src     = ctl.pc_src;
   assign reg_dst    = ctl.reg_dst;
   assign wb_sel     = ctl.wb_sel;
   assign reg_wr     = ctl.reg_wr;

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
   parameter bit ENABLE_ADDI = 1'b1
) (
   input logic       clk,
   input logic       rst,
   input logic [5:0] op_i,
   input logic [3:0] state_o,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic       pc_wr,
   input logic       pc_wr_cond,
   input logic       reg_wr
);

   logic op_known;
   assign op_known = (op_i == 6'b100011) || (op_i == 6'b101011) ||
                     (op_i == 6'b000000) || (op_i == 6'b000100) ||
                     (op_i == 6'b000010) || (ENABLE_ADDI && (op_i == 6'b001000));

   AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
      (state_o == 4'd0) |=> (state_o == 4'd1));                          // R2
   AST_LOAD_READ_TO_WB: assert property (@(posedge clk) disable iff (rst)
      (state_o == 4'd3) |=> (state_o == 4'd4));                          // R4
   AST_STORE_SPLIT: assert property (@(posedge clk) disable iff (rst)
      (state_o == 4'd2 && op_i == 6'b101011) |=> (state_o == 4'd5));     // R5
   AST_BRANCH_COND_ONLY: assert property (@(posedge clk) disable iff (rst)
      (state_o == 4'd8) |-> (pc_wr_cond && !pc_wr));                     // R7
   AST_JUMP_RETURN: assert property (@(posedge clk) disable iff (rst)
      (state_o == 4'd9) |=> (state_o == 4'd0));                          // R8
   AST_ADDI_EXEC_TO_WB: assert property (@(posedge clk) disable iff (rst)
      (state_o == 4'd10) |=> (state_o == 4'd11));                        // R9
   AST_ADDI_WB_RETURN: assert property (@(posedge clk) disable iff (rst)
      (state_o == 4'd11) |=> (state_o == 4'd0));                         // R9
   AST_UNKNOWN_OP_FETCH: assert property (@(posedge clk) disable iff (rst)
      (state_o == 4'd1 && !op_known) |=> (state_o == 4'd0));             // R10
   AST_REGWR_IN_WB_ONLY: assert property (@(posedge clk) disable iff (rst)
      reg_wr |-> (state_o == 4'd4 || state_o == 4'd7 || state_o == 4'd11)); // R11
   AST_MEMWR_IN_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
      mem_wr |-> (state_o == 4'd5));                                     // R11
   AST_MEM_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));                                              // R12
   AST_PC_LOAD_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(pc_wr && pc_wr_cond));                                           // R12

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(
   .ENABLE_ADDI (ENABLE_ADDI)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .op_i       (op_i),
   .state_o    (state_o),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .pc_wr      (pc_wr),
   .pc_wr_cond (pc_wr_cond),
   .reg_wr     (reg_wr)
);

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] op_i = 6'b0;
   logic [3:0] state_o;
   logic       mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, addr_sel, srca_sel;
   logic [1:0] srcb_sel, alu_op, pc_src;
   logic       reg_dst, wb_sel, reg_wr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   mc_ctrl_fsm dut (
      .clk (clk), .rst (rst), .op_i (op_i), .state_o (state_o),
      .mem_rd (mem_rd), .mem_wr (mem_wr), .ir_wr (ir_wr), .pc_wr (pc_wr),
      .pc_wr_cond (pc_wr_cond), .addr_sel (addr_sel), .srca_sel (srca_sel),
      .srcb_sel (srcb_sel), .alu_op (alu_op), .pc_src (pc_src),
      .reg_dst (reg_dst), .wb_sel (wb_sel), .reg_wr (reg_wr)
   );

   // bit order: mem_rd mem_wr ir_wr pc_wr pc_wr_cond addr_sel srca_sel
   //            srcb_sel[1:0] alu_op[1:0] pc_src[1:0] reg_dst wb_sel reg_wr
   wire [15:0] ctl_act = {mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, addr_sel,
                          srca_sel, srcb_sel, alu_op, pc_src, reg_dst, wb_sel, reg_wr};

   function automatic logic [15:0] exp_ctl(input logic [3:0] s);
      case (s)
         4'd0:  return {1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b01,2'b00,2'b00,1'b0,1'b0,1'b0}; // R2
         4'd1:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,2'b00,1'b0,1'b0,1'b0}; // R3
         4'd2:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b00,2'b00,1'b0,1'b0,1'b0}; // R4
         4'd3:  return {1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0}; // R4
         4'd4:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b1,1'b1}; // R4
         4'd5:  return {1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0}; // R5
         4'd6:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b10,2'b00,1'b0,1'b0,1'b0}; // R6
         4'd7:  return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,1'b1,1'b0,1'b1}; // R6
         4'd8:  return {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,2'b00,2'b01,2'b01,1'b0,1'b0,1'b0}; // R7
         4'd9:  return {1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,2'b10,1'b0,1'b0,1'b0}; // R8
         4'd10: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b00,2'b00,1'b0,1'b0,1'b0}; // R9
         4'd11: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,1'b0,1'b0,1'b1}; // R9
         default: return 16'h0;
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_state(input string req, input logic [3:0] exp_s);
      chk(req, "state", {12'h0, state_o}, {12'h0, exp_s});
      chk(req, "controls", ctl_act, exp_ctl(exp_s));
   endtask

   // Entered at a falling edge with the sequencer in fetch.
   task automatic run_instr(input string req, input logic [5:0] op, input int n,
                            input logic [3:0] s2, input logic [3:0] s3,
                            input logic [3:0] s4);
      logic [3:0] seq [5];
      seq[0] = 4'd0; seq[1] = 4'd1; seq[2] = s2; seq[3] = s3; seq[4] = s4;
      op_i = op;
      for (int i = 0; i < n; i++) begin
         chk_state(req, seq[i]);
         @(negedge clk);
      end
      chk(req, "return to fetch", {12'h0, state_o}, 16'h0);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      op_i = 6'b100011;
      @(negedge clk);
      @(negedge clk);
      chk_state("R1", 4'd0);
      rst = 1'b0;
   endtask

   task automatic t_reset_midway;
      op_i = 6'b100011;
      @(negedge clk);          // decode
      @(negedge clk);          // address state
      chk_state("R4", 4'd2);
      rst = 1'b1;
      @(negedge clk);
      chk_state("R1", 4'd0);
      rst = 1'b0;
      @(negedge clk);
      chk_state("R1", 4'd1);
      op_i = 6'b111111;
      @(negedge clk);
      chk_state("R10", 4'd0);
   endtask

   task automatic t_unknown_ops;
      logic [5:0] bad [3];
      bad[0] = 6'b111111; bad[1] = 6'b000001; bad[2] = 6'b100000;
      for (int k = 0; k < 3; k++) begin
         run_instr("R10", bad[k], 2, 4'd0, 4'd0, 4'd0);
      end
   endtask

   initial begin
      t_reset();
      run_instr("R4", 6'b100011, 5, 4'd2, 4'd3, 4'd4);
      run_instr("R5", 6'b101011, 4, 4'd2, 4'd5, 4'd0);
      run_instr("R6", 6'b000000, 4, 4'd6, 4'd7, 4'd0);
      run_instr("R7", 6'b000100, 3, 4'd8, 4'd0, 4'd0);
      run_instr("R8", 6'b000010, 3, 4'd9, 4'd0, 4'd0);
      run_instr("R9", 6'b001000, 4, 4'd10, 4'd11, 4'd0);
      t_unknown_ops();
      run_instr("R11", 6'b101011, 4, 4'd2, 4'd5, 4'd0);
      run_instr("R12", 6'b100011, 5, 4'd2, 4'd3, 4'd4);
      run_instr("R3", 6'b001000, 4, 4'd10, 4'd11, 4'd0);
      t_reset_midway();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule